// File: doc/BRIEF.md
# Interrupt Flag and Mask Controller

This block sits beside a small microcontroller core and decides which interrupt the core should take next. It watches two external request pins and four timer event flags. It holds two byte-wide registers on the core's I/O register bus. The first is a flag register that latches edge events on the two pins. The second is a timer enable register that gates the four timer events.

Each pin has a 2-bit sense mode. In an edge mode, the chosen transition latches a flag that stays set until software clears it or the core takes the vector. Software clears a flag by writing a one to its bit. In low-level mode, the pin keeps no flag at all and requests only while it is held low.

Every pending source must have its own enable and the global enable set before it can request. When it does, the block raises a request and gives the vector number of the winning source. The lowest vector number wins. When the core pulses the acknowledge, the block clears the hardware flag behind the vector it was showing.

Top module: `irq_flagmask_ctrl`

## Requirements
- R1: The flag register is read and written at I/O address 0x3A. The pin-1 flag is in bit 7 and the pin-0 flag is in bit 6. Bits 5..0 always read as zero. The register reads 0x00 after reset.
- R2: The timer enable register is at I/O address 0x39. Bits 7 (timer-1 overflow), 6 (timer-1 compare A), 3 (timer-1 capture) and 1 (timer-0 overflow) are read/write. Bits 5, 4, 2 and 0 always read as zero. The register reads 0x00 after reset.
- R3: Sense mode 01 sets a pin's flag on any edge, 10 on a falling edge and 11 on a rising edge. The opposite edge in modes 10 and 11 leaves the flag clear. A set flag is visible three clock edges after the pin changes: two synchronizer stages, then the flag register.
- R4: A write to 0x3A with a one in bit 6 or bit 7 clears that flag. A zero in that bit leaves the flag unchanged.
- R5: In sense mode 00 the pin's flag is held at zero. The pin requests only while its synchronized level is low, and the request ends two edges after the pin goes high.
- R6: An acknowledge pulse clears the flag of pin 0 when the shown vector is 1, and the flag of pin 1 when it is 2.
- R7: A source requests only when its own enable and glob_ie are both set. ext_en[i] is the enable for pin i. The timer events use the matching bit of the enable register with the same bit of tmr_flag.
- R8: The vectors are: pin 0 = 1, pin 1 = 2, capture = 3, compare A = 4, timer-1 overflow = 5, timer-0 overflow = 6. When several sources request, the lowest vector wins. irq_vec is 0 when irq_req is low. Both outputs follow their inputs in the same cycle.
- R9: If an edge event and a clear (a write-one or an acknowledge) reach the same flag on the same edge, the flag ends up set.
- R10: Writes to any other address change neither register, and reads from any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O register address |
| io_we | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for io_addr (combinational) |
| ext_pin | input | 2 | External interrupt pins, asynchronous |
| sense_mode | input | 4 | Two bits per pin: [1:0] pin 0, [3:2] pin 1 |
| ext_en | input | 2 | Per-pin interrupt enable |
| tmr_flag | input | 8 | Timer event flags, laid out like the enable register |
| glob_ie | input | 1 | Global interrupt enable |
| ack | input | 1 | Vector-taken pulse |
| irq_req | output | 1 | A request is pending and enabled |
| irq_vec | output | 3 | Vector of the winning request, 0 if none |

## Verification
The results fall due at different times after a stimulus:

- An edge flag appears on the third rising edge after the pin changes.
- A level request appears, or ends, on the second edge.
- Register writes and acknowledge clears show after one edge.
- The request and vector follow the enables and timer flags in the same cycle.

The bench drives every input just after a falling edge and reads back just after a later falling edge, counting the rising edges in between. Where a result is due on edge N, it also checks that nothing has changed by edge N-1.

// File: rtl/irq_fm_pkg.sv
package irq_fm_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_ANY  = 2'b01,
      SENSE_FALL = 2'b10,
      SENSE_RISE = 2'b11
   } sense_e;

   localparam int VEC_W = 3;

endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense
   import irq_fm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_i,
   input  logic [1:0] mode_i,
   output logic       edge_ev_o,
   output logic       level_act_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_pin_sense: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   smp;
   logic                   rise;
   logic                   fall;

   assign smp = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '1;
         prev_q <= 1'b1;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
         prev_q <= smp;
      end
   end

   assign rise = smp & ~prev_q;
   assign fall = ~smp & prev_q;

   always_comb begin
      edge_ev_o   = 1'b0;
      level_act_o = 1'b0;
      case (sense_e'(mode_i))
         SENSE_LOW:  level_act_o = ~smp;
         SENSE_ANY:  edge_ev_o   = rise | fall;
         SENSE_FALL: edge_ev_o   = fall;
         SENSE_RISE: edge_ev_o   = rise;
         default:    edge_ev_o   = 1'b0;
      endcase
   end

endmodule

// File: rtl/irq_ext_flags.sv
module irq_ext_flags #(
   parameter int N_EXT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EXT-1:0] set_i,
   input  logic [N_EXT-1:0] clr_i,
   input  logic [N_EXT-1:0] hold_zero_i,
   output logic [N_EXT-1:0] flag_q
);

   for (genvar g = 0; g < N_EXT; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flag_q[g] <= 1'b0;
         end else if (hold_zero_i[g]) begin
            flag_q[g] <= 1'b0;
         end else if (set_i[g]) begin
            flag_q[g] <= 1'b1;
         end else if (clr_i[g]) begin
            flag_q[g] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
   parameter int N_SRC = 6,
   parameter int VEC_W = 3
) (
   input  logic [N_SRC-1:0] src_i,
   output logic             req_o,
   output logic [VEC_W-1:0] vec_o
);

   if (N_SRC >= (1 << VEC_W)) begin : g_bad_width
      $error("irq_prio_enc: VEC_W too narrow for N_SRC");
   end

   assign req_o = |src_i;

   always_comb begin
      vec_o = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (src_i[i]) vec_o = VEC_W'(i + 1);
      end
   end

endmodule

// File: rtl/irq_flagmask_ctrl.sv
module irq_flagmask_ctrl
   import irq_fm_pkg::*;
#(
   parameter int              ADDR_W      = 6,
   parameter int              DATA_W      = 8,
   parameter int              N_EXT       = 2,
   parameter int              SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3A,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h39
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    io_addr,
   input  logic                 io_we,
   input  logic [DATA_W-1:0]    io_wdata,
   output logic [DATA_W-1:0]    io_rdata,
   input  logic [N_EXT-1:0]     ext_pin,
   input  logic [2*N_EXT-1:0]   sense_mode,
   input  logic [N_EXT-1:0]     ext_en,
   input  logic [DATA_W-1:0]    tmr_flag,
   input  logic                 glob_ie,
   input  logic                 ack,
   output logic                 irq_req,
   output logic [VEC_W-1:0]     irq_vec
);

   localparam int              FLAG_LSB = DATA_W - N_EXT;
   localparam int              B_OVF1   = 7;
   localparam int              B_CMPA   = 6;
   localparam int              B_CAP    = 3;
   localparam int              B_OVF0   = 1;
   localparam logic [DATA_W-1:0] MASK_RW =
      DATA_W'((1 << B_OVF1) | (1 << B_CMPA) | (1 << B_CAP) | (1 << B_OVF0));
   localparam int              N_TMR    = 4;
   localparam int              N_SRC    = N_EXT + N_TMR;

   if (DATA_W != 8) begin : g_bad_data
      $error("irq_flagmask_ctrl: DATA_W must be 8");
   end
   if (N_EXT != 2) begin : g_bad_ext
      $error("irq_flagmask_ctrl: N_EXT must be 2");
   end
   if (FLAG_ADDR == MASK_ADDR) begin : g_bad_addr
      $error("irq_flagmask_ctrl: register addresses collide");
   end

   logic [N_EXT-1:0]  edge_ev;
   logic [N_EXT-1:0]  level_act;
   logic [N_EXT-1:0]  lvl_mode;
   logic [N_EXT-1:0]  wr_clr;
   logic [N_EXT-1:0]  ack_clr;
   logic [N_EXT-1:0]  flag_q;
   logic [DATA_W-1:0] mask_q;
   logic [N_SRC-1:0]  src;
   logic              wr_flag;
   logic              wr_mask;

   assign wr_flag = io_we && (io_addr == FLAG_ADDR);
   assign wr_mask = io_we && (io_addr == MASK_ADDR);

   for (genvar g = 0; g < N_EXT; g++) begin : g_pin
      irq_pin_sense #(
         .SYNC_STAGES (SYNC_STAGES)
      ) sense_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .pin_i       (ext_pin[g]),
         .mode_i      (sense_mode[2*g +: 2]),
         .edge_ev_o   (edge_ev[g]),
         .level_act_o (level_act[g])
      );
      assign lvl_mode[g] = (sense_mode[2*g +: 2] == SENSE_LOW);
      assign wr_clr[g]   = wr_flag && io_wdata[FLAG_LSB + g];
      assign ack_clr[g]  = ack && irq_req && (irq_vec == VEC_W'(g + 1));
      assign src[g]      = glob_ie && ext_en[g] && (flag_q[g] || level_act[g]);
   end

   irq_ext_flags #(
      .N_EXT (N_EXT)
   ) flags_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_i       (edge_ev),
      .clr_i       (wr_clr | ack_clr),
      .hold_zero_i (lvl_mode),
      .flag_q      (flag_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_mask) begin
         mask_q <= io_wdata & MASK_RW;
      end
   end

   assign src[N_EXT + 0] = glob_ie && mask_q[B_CAP]  && tmr_flag[B_CAP];
   assign src[N_EXT + 1] = glob_ie && mask_q[B_CMPA] && tmr_flag[B_CMPA];
   assign src[N_EXT + 2] = glob_ie && mask_q[B_OVF1] && tmr_flag[B_OVF1];
   assign src[N_EXT + 3] = glob_ie && mask_q[B_OVF0] && tmr_flag[B_OVF0];

   irq_prio_enc #(
      .N_SRC (N_SRC),
      .VEC_W (VEC_W)
   ) prio_i (
      .src_i (src),
      .req_o (irq_req),
      .vec_o (irq_vec)
   );

   always_comb begin
      io_rdata = '0;
      if (io_addr == FLAG_ADDR) begin
         io_rdata[FLAG_LSB +: N_EXT] = flag_q;
      end else if (io_addr == MASK_ADDR) begin
         io_rdata = mask_q;
      end
   end

endmodule

// File: rtl/irq_fm_chk.sv
module irq_fm_chk #(
   parameter int              ADDR_W    = 6,
   parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3A,
   parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h39
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] io_addr,
   input logic              io_we,
   input logic [7:0]        io_wdata,
   input logic [7:0]        io_rdata,
   input logic [3:0]        sense_mode,
   input logic              glob_ie,
   input logic              ack,
   input logic              irq_req,
   input logic [2:0]        irq_vec,
   input logic [1:0]        flag_q,
   input logic [1:0]        edge_ev
);

   p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr == FLAG_ADDR) |-> (io_rdata[5:0] == 6'd0));

   p_mask_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_addr == MASK_ADDR) |-> ((io_rdata & 8'h35) == 8'd0));

   p_w1c_pin0_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_we && io_addr == FLAG_ADDR && io_wdata[6] && !edge_ev[0]) |=> !flag_q[0]);

   p_w1c_pin1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (io_we && io_addr == FLAG_ADDR && io_wdata[7] && !edge_ev[1]) |=> !flag_q[1]);

   p_level_noflag0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_mode[1:0] == 2'b00) |=> !flag_q[0]);

   p_level_noflag1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sense_mode[3:2] == 2'b00) |=> !flag_q[1]);

   p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && irq_vec == 3'd1 && !edge_ev[0]) |=> !flag_q[0]);

   p_gie_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !glob_ie |-> !irq_req);

   p_idle_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> (irq_vec == 3'd0));

   p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      edge_ev[0] |=> flag_q[0]);

endmodule

bind irq_flagmask_ctrl irq_fm_chk #(
   .ADDR_W    (ADDR_W),
   .FLAG_ADDR (FLAG_ADDR),
   .MASK_ADDR (MASK_ADDR)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .io_addr    (io_addr),
   .io_we      (io_we),
   .io_wdata   (io_wdata),
   .io_rdata   (io_rdata),
   .sense_mode (sense_mode),
   .glob_ie    (glob_ie),
   .ack        (ack),
   .irq_req    (irq_req),
   .irq_vec    (irq_vec),
   .flag_q     (flag_q),
   .edge_ev    (edge_ev)
);

// File: tb/irq_flagmask_ctrl_tb.sv
module irq_flagmask_ctrl_tb_top;

   localparam int          CLK_PERIOD = 10;
   localparam logic [5:0]  A_FLAG = 6'h3A;
   localparam logic [5:0]  A_MASK = 6'h39;
   localparam int          N_TBL  = 8;

   // {mask write, tmr_flag, glob_ie, exp req, exp vec}
   localparam logic [20:0] TBL [N_TBL] = '{
      {8'hCA, 8'hCA, 1'b1, 1'b1, 3'd3},
      {8'hC2, 8'hCA, 1'b1, 1'b1, 3'd4},
      {8'h82, 8'hCA, 1'b1, 1'b1, 3'd5},
      {8'h02, 8'hCA, 1'b1, 1'b1, 3'd6},
      {8'hCA, 8'hCA, 1'b0, 1'b0, 3'd0},
      {8'h00, 8'hFF, 1'b1, 1'b0, 3'd0},
      {8'hFF, 8'h35, 1'b1, 1'b0, 3'd0},
      {8'h40, 8'hC0, 1'b1, 1'b1, 3'd4}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] io_addr = '0;
   logic       io_we = 1'b0;
   logic [7:0] io_wdata = '0;
   logic [7:0] io_rdata;
   logic [1:0] ext_pin = 2'b11;
   logic [3:0] sense_mode = 4'b0101;
   logic [1:0] ext_en = 2'b00;
   logic [7:0] tmr_flag = '0;
   logic       glob_ie = 1'b0;
   logic       ack = 1'b0;
   logic       irq_req;
   logic [2:0] irq_vec;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_flagmask_ctrl dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .io_addr    (io_addr),
      .io_we      (io_we),
      .io_wdata   (io_wdata),
      .io_rdata   (io_rdata),
      .ext_pin    (ext_pin),
      .sense_mode (sense_mode),
      .ext_en     (ext_en),
      .tmr_flag   (tmr_flag),
      .glob_ie    (glob_ie),
      .ack        (ack),
      .irq_req    (irq_req),
      .irq_vec    (irq_vec)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic io_wr(input logic [5:0] a, input logic [7:0] d);
      io_addr = a;
      io_wdata = d;
      io_we = 1'b1;
      tick(1);
      io_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [5:0] a, input logic [7:0] exp);
      io_addr = a;
      #1;
      check(tag, io_rdata, exp);
   endtask

   task automatic req_chk(input string tag, input logic r, input logic [2:0] v);
      #1;
      check({tag, " req"}, {7'd0, irq_req}, {7'd0, r});
      check({tag, " vec"}, {5'd0, irq_vec}, {5'd0, v});
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog timeout");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // reset state R1 R2 R8
      rd_chk("R1 flag reset", A_FLAG, 8'h00);
      rd_chk("R2 mask reset", A_MASK, 8'h00);
      req_chk("R8 idle after reset", 1'b0, 3'd0);

      // table walk: timer enables, priority, global enable R2 R7 R8
      for (int i = 0; i < N_TBL; i++) begin
         io_wr(A_MASK, TBL[i][20:13]);
         tmr_flag = TBL[i][12:5];
         glob_ie  = TBL[i][4];
         rd_chk($sformatf("R2 mask readback %0d", i), A_MASK, TBL[i][20:13] & 8'hCA);
         req_chk($sformatf("R7 R8 table %0d", i), TBL[i][3], TBL[i][2:0]);
      end
      io_wr(A_MASK, 8'h00);
      tmr_flag = 8'h00;
      glob_ie = 1'b1;

      // falling edge on pin 0, R3
      sense_mode[1:0] = 2'b10;
      tick(1);
      ext_pin[0] = 1'b0;
      tick(2);
      rd_chk("R3 fall not yet", A_FLAG, 8'h00);
      tick(1);
      rd_chk("R3 fall sets flag0", A_FLAG, 8'h40);
      req_chk("R7 no req without ext_en", 1'b0, 3'd0);
      ext_en = 2'b11;
      req_chk("R8 pin0 vector", 1'b1, 3'd1);

      // write-one-clear R4
      io_wr(A_FLAG, 8'h80);
      rd_chk("R4 zero bit keeps flag0", A_FLAG, 8'h40);
      io_wr(A_FLAG, 8'h40);
      rd_chk("R4 one clears flag0", A_FLAG, 8'h00);

      // rising mode R3
      sense_mode[1:0] = 2'b11;
      ext_pin[0] = 1'b1;
      tick(3);
      rd_chk("R3 rise sets flag0", A_FLAG, 8'h40);
      io_wr(A_FLAG, 8'h40);
      ext_pin[0] = 1'b0;
      tick(4);
      rd_chk("R3 rise mode ignores fall", A_FLAG, 8'h00);

      // both flags, priority and acknowledge R6 R8
      sense_mode = 4'b0101;
      ext_pin[1] = 1'b0;
      tick(3);
      rd_chk("R3 any-edge flag1", A_FLAG, 8'h80);
      ext_pin[0] = 1'b1;
      tick(3);
      rd_chk("R3 any-edge flag0", A_FLAG, 8'hC0);
      io_wr(A_MASK, 8'h08);
      tmr_flag = 8'h08;
      req_chk("R8 pin0 wins", 1'b1, 3'd1);
      ack = 1'b1;
      tick(1);
      ack = 1'b0;
      rd_chk("R6 ack clears flag0", A_FLAG, 8'h80);
      req_chk("R8 pin1 beats capture", 1'b1, 3'd2);
      ack = 1'b1;
      tick(1);
      ack = 1'b0;
      rd_chk("R6 ack clears flag1", A_FLAG, 8'h00);
      req_chk("R8 capture after acks", 1'b1, 3'd3);
      tmr_flag = 8'h00;

      // level mode R5 R7
      ext_pin[1] = 1'b1;
      tick(3);
      rd_chk("R3 flag1 before level", A_FLAG, 8'h80);
      sense_mode[3:2] = 2'b00;
      tick(1);
      rd_chk("R5 level clears flag1", A_FLAG, 8'h00);
      req_chk("R5 level high no req", 1'b0, 3'd0);
      ext_pin[1] = 1'b0;
      tick(1);
      req_chk("R5 level after one edge", 1'b0, 3'd0);
      tick(1);
      req_chk("R5 level low requests", 1'b1, 3'd2);
      rd_chk("R5 level keeps no flag", A_FLAG, 8'h00);
      glob_ie = 1'b0;
      req_chk("R7 glob_ie gates level", 1'b0, 3'd0);
      glob_ie = 1'b1;
      ext_pin[1] = 1'b1;
      tick(1);
      req_chk("R5 still low in sync", 1'b1, 3'd2);
      tick(1);
      req_chk("R5 request gone", 1'b0, 3'd0);

      // simultaneous set and clear R9
      ext_pin[0] = 1'b0;
      tick(2);
      io_wr(A_FLAG, 8'h40);
      rd_chk("R9 set beats write clear", A_FLAG, 8'h40);

      // other address R10
      io_wr(6'h38, 8'hFF);
      rd_chk("R10 flag untouched", A_FLAG, 8'h40);
      rd_chk("R10 mask untouched", A_MASK, 8'h08);
      rd_chk("R10 other reads zero", 6'h38, 8'h00);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule